// File: doc/BRIEF.md
# Fly-by Read-to-Write Transfer Decoder

This block is the address decode and strobe glue between a host with a multiplexed address/data bus, an external SRAM and a network controller's data port. In normal operation it decodes the latched host address into chip selects and read/write strobes for the two devices.

When the armed input is high and the host reads an address inside a fixed transfer window, the block turns that read into a fly-by cycle. The network controller is selected and read, so its data port drives the shared data bus. In the same cycle the SRAM gets a write strobe at the address the host supplied, and its output enable stays off. The host throws away the data it reads. Each byte moves straight from the controller into SRAM, at one host bus instruction per byte. Write cycles always decode to their normal targets.

The low address byte is captured from the multiplexed bus on any clock edge where the address-latch input is high. Strobe outputs are combinational from the captured address and the live host strobes. All strobes are active high.

Top module: `flyby_glue`

## Requirements
- R1: On a rising clock edge with `ale_i` high, the low address byte is captured from `ad_lo_i`. With `ale_i` low it is held, so later changes on `ad_lo_i` do not alter decoding.
- R2: With `arm_i` low, a read anywhere in the SRAM range (0x1100..0x7FFF, including the window) asserts `sram_cs_o` and `sram_oe_o` only. `sram_we_o`, `nic_cs_o` and `nic_rd_o` stay low.
- R3: With `arm_i` high, a read inside the window (0x4000..0x40FF) asserts `sram_cs_o`, `sram_we_o`, `nic_cs_o` and `nic_rd_o`, and keeps `sram_oe_o` and `nic_wr_o` low.
- R4: With `arm_i` high, a read in the SRAM range outside the window decodes as a normal SRAM read (`sram_cs_o`, `sram_oe_o`).
- R5: `sram_oe_o` and `nic_rd_o` are never high together.
- R6: A write cycle is never converted. A write into the window, armed or not, asserts only `sram_cs_o` and `sram_we_o`.
- R7: Accesses to the controller range (0x8300..0x830F) assert `nic_cs_o` with `nic_rd_o` on a read or `nic_wr_o` on a write, whatever the state of `arm_i`.
- R8: An access to an address outside every range leaves all six strobe outputs low.
- R9: Outputs follow the host strobes in the same cycle. The fly-by SRAM write pulse ends when `rd_i` falls, and with both strobes low every output is low.
- R10: After reset the captured low byte is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the address capture |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_hi_i | input | 8 | Non-multiplexed upper address bits |
| ad_lo_i | input | 8 | Multiplexed bus, low address byte phase |
| ale_i | input | 1 | Address-latch enable |
| rd_i | input | 1 | Host read strobe |
| wr_i | input | 1 | Host write strobe |
| arm_i | input | 1 | Fly-by mode enable |
| sram_cs_o | output | 1 | SRAM chip select |
| sram_oe_o | output | 1 | SRAM output enable |
| sram_we_o | output | 1 | SRAM write enable |
| nic_cs_o | output | 1 | Network controller chip select |
| nic_rd_o | output | 1 | Network controller read strobe |
| nic_wr_o | output | 1 | Network controller write strobe |

## Verification
The same window address is read first disarmed and then armed, which separates the fly-by conversion from plain decode. An armed read just outside the window, at 0x4100, shows that the window boundary is exact. Armed writes into the window and armed controller accesses show that only reads are converted. A read of an unmapped address gives the all-low case. After each access the strobes are released, which shows that the write pulse ends together with the read strobe. A capture test changes the multiplexed byte after the latch phase, to tell a held address from a transparent one.

// File: rtl/flyby_pkg.sv
package flyby_pkg;
  localparam int unsigned N_RGN   = 3;
  localparam int unsigned RG_SRAM = 0;
  localparam int unsigned RG_WIN  = 1;
  localparam int unsigned RG_NIC  = 2;

  typedef struct packed {
    logic sram_cs;
    logic sram_oe;
    logic sram_we;
    logic nic_cs;
    logic nic_rd;
    logic nic_wr;
  } strobe_t;
endpackage

// File: rtl/addr_capture.sv
module addr_capture #(
  parameter int unsigned LO_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ale_i,
  input  logic [LO_W-1:0] ad_lo_i,
  output logic [LO_W-1:0] lo_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    lo_q_o <= '0;
    else if (ale_i) lo_q_o <= ad_lo_i;
  end

  p_lat_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ale_i |=> $stable(lo_q_o));
endmodule

// File: rtl/addr_decode.sv
module addr_decode #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned N      = 3,
  parameter logic [N-1:0][ADDR_W-1:0] BASE = '0,
  parameter logic [N-1:0][ADDR_W-1:0] LAST = '0
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [N-1:0]      hit_o
);
  for (genvar g = 0; g < N; g++) begin : g_rgn
    assign hit_o[g] = (addr_i >= BASE[g]) && (addr_i <= LAST[g]);
  end
endmodule

// File: rtl/flyby_strobe.sv
module flyby_strobe
  import flyby_pkg::*;
(
  input  logic [N_RGN-1:0] hit_i,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic             arm_i,
  output strobe_t          stb_o
);
  logic fly;
  logic sram_acc, nic_acc;

  // only reads convert; a concurrent write blocks conversion
  assign fly      = arm_i & hit_i[RG_WIN] & hit_i[RG_SRAM] & rd_i & ~wr_i;
  assign sram_acc = hit_i[RG_SRAM] & (rd_i | wr_i);
  assign nic_acc  = hit_i[RG_NIC] & (rd_i | wr_i);

  always_comb begin
    stb_o.sram_cs = sram_acc;
    stb_o.sram_oe = hit_i[RG_SRAM] & rd_i & ~fly;
    stb_o.sram_we = (hit_i[RG_SRAM] & wr_i) | fly;
    stb_o.nic_cs  = nic_acc | fly;
    stb_o.nic_rd  = (hit_i[RG_NIC] & rd_i) | fly;
    stb_o.nic_wr  = hit_i[RG_NIC] & wr_i;
  end
endmodule

// File: rtl/flyby_glue.sv
module flyby_glue
  import flyby_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned LO_W      = 8,
  parameter logic [ADDR_W-1:0] SRAM_BASE = 16'h1100,
  parameter logic [ADDR_W-1:0] SRAM_LAST = 16'h7FFF,
  parameter logic [ADDR_W-1:0] WIN_BASE  = 16'h4000,
  parameter logic [ADDR_W-1:0] WIN_LAST  = 16'h40FF,
  parameter logic [ADDR_W-1:0] NIC_BASE  = 16'h8300,
  parameter logic [ADDR_W-1:0] NIC_LAST  = 16'h830F
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [ADDR_W-LO_W-1:0] addr_hi_i,
  input  logic [LO_W-1:0]        ad_lo_i,
  input  logic                   ale_i,
  input  logic                   rd_i,
  input  logic                   wr_i,
  input  logic                   arm_i,
  output logic                   sram_cs_o,
  output logic                   sram_oe_o,
  output logic                   sram_we_o,
  output logic                   nic_cs_o,
  output logic                   nic_rd_o,
  output logic                   nic_wr_o
);
  localparam logic [N_RGN-1:0][ADDR_W-1:0] RG_BASE = {NIC_BASE, WIN_BASE, SRAM_BASE};
  localparam logic [N_RGN-1:0][ADDR_W-1:0] RG_LAST = {NIC_LAST, WIN_LAST, SRAM_LAST};

  logic [LO_W-1:0]   lo_q;
  logic [ADDR_W-1:0] addr;
  logic [N_RGN-1:0]  hit;
  strobe_t           stb;

  addr_capture #(.LO_W(LO_W)) u_cap (
    .clk_i(clk_i), .rst_ni(rst_ni), .ale_i(ale_i), .ad_lo_i(ad_lo_i), .lo_q_o(lo_q)
  );

  assign addr = {addr_hi_i, lo_q};

  addr_decode #(.ADDR_W(ADDR_W), .N(N_RGN), .BASE(RG_BASE), .LAST(RG_LAST)) u_dec (
    .addr_i(addr), .hit_o(hit)
  );

  flyby_strobe u_stb (
    .hit_i(hit), .rd_i(rd_i), .wr_i(wr_i), .arm_i(arm_i), .stb_o(stb)
  );

  assign sram_cs_o = stb.sram_cs;
  assign sram_oe_o = stb.sram_oe;
  assign sram_we_o = stb.sram_we;
  assign nic_cs_o  = stb.nic_cs;
  assign nic_rd_o  = stb.nic_rd;
  assign nic_wr_o  = stb.nic_wr;

  p_no_contention_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_oe_o |-> !nic_rd_o);
  p_flyby_pair_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sram_we_o && rd_i && !wr_i) |-> (nic_rd_o && nic_cs_o && sram_cs_o));
  p_disarmed_plain_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!arm_i && rd_i && !wr_i) |-> !sram_we_o);
  p_wr_not_converted_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !rd_i) |-> !nic_rd_o && !sram_oe_o);
  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_i && !wr_i) |-> !(sram_cs_o || sram_we_o || nic_cs_o || nic_rd_o || nic_wr_o));
endmodule

// File: tb/flyby_glue_test.sv
module flyby_glue_test;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 0, rst_n = 0;
  logic [7:0] addr_hi = 0, ad_lo = 0;
  logic       ale = 0, rd = 0, wr = 0, arm = 0;
  logic       sram_cs, sram_oe, sram_we, nic_cs, nic_rd, nic_wr;
  int         checks = 0, failures = 0;
  bit         done = 0;

  // expected vector order: {sram_cs, sram_oe, sram_we, nic_cs, nic_rd, nic_wr}
  localparam logic [5:0] E_IDLE  = 6'b000000;
  localparam logic [5:0] E_SRD   = 6'b110000;
  localparam logic [5:0] E_SWR   = 6'b101000;
  localparam logic [5:0] E_FLY   = 6'b101110;
  localparam logic [5:0] E_NRD   = 6'b000110;
  localparam logic [5:0] E_NWR   = 6'b000101;

  always #(CLK_PERIOD/2) clk = ~clk;

  flyby_glue uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_hi_i(addr_hi), .ad_lo_i(ad_lo), .ale_i(ale),
    .rd_i(rd), .wr_i(wr), .arm_i(arm),
    .sram_cs_o(sram_cs), .sram_oe_o(sram_oe), .sram_we_o(sram_we),
    .nic_cs_o(nic_cs), .nic_rd_o(nic_rd), .nic_wr_o(nic_wr)
  );

  task automatic check(input string req, input logic [5:0] exp);
    logic [5:0] act;
    act = {sram_cs, sram_oe, sram_we, nic_cs, nic_rd, nic_wr};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic latch_addr(input logic [15:0] a);
    @(negedge clk);
    addr_hi = a[15:8]; ad_lo = a[7:0]; ale = 1;
    @(negedge clk);
    ale = 0; ad_lo = 8'hA5;
  endtask

  // full access: latch, strobe, check, release, check idle
  task automatic access(input string req, input logic [15:0] a, input logic r,
                        input logic w, input logic armed, input logic [5:0] exp);
    arm = armed;
    latch_addr(a);
    rd = r; wr = w;
    #1 check(req, exp);
    @(negedge clk);
    rd = 0; wr = 0;
    #1 check({req, "_R9_release"}, E_IDLE);
  endtask

  task automatic t_reset;
    addr_hi = 8'h83; ad_lo = 8'h20;
    #1 check("R10_idle", E_IDLE);
    rd = 1;
    #1 check("R10_low_byte_zero", E_NRD);
    rd = 0;
  endtask

  task automatic t_disarmed;
    access("R2_window", 16'h4010, 1, 0, 0, E_SRD);
    access("R2_sram_low", 16'h1100, 1, 0, 0, E_SRD);
  endtask

  task automatic t_flyby;
    access("R3_win_base", 16'h4000, 1, 0, 1, E_FLY);
    access("R3_win_last", 16'h40FF, 1, 0, 1, E_FLY);
    access("R4_above_win", 16'h4100, 1, 0, 1, E_SRD);
    access("R4_below_win", 16'h3FFF, 1, 0, 1, E_SRD);
  endtask

  task automatic t_writes;
    access("R6_armed_wr", 16'h4020, 0, 1, 1, E_SWR);
    access("R6_plain_wr", 16'h4020, 0, 1, 0, E_SWR);
  endtask

  task automatic t_nic;
    access("R7_rd_armed", 16'h8305, 1, 0, 1, E_NRD);
    access("R7_wr_armed", 16'h830F, 0, 1, 1, E_NWR);
    access("R7_rd_plain", 16'h8300, 1, 0, 0, E_NRD);
  endtask

  task automatic t_unmapped;
    access("R8_gap", 16'h8310, 1, 0, 1, E_IDLE);
    access("R8_low", 16'h0040, 0, 1, 0, E_IDLE);
  endtask

  task automatic t_hold;
    arm = 0;
    latch_addr(16'h8305);
    ad_lo = 8'h20;
    @(negedge clk);
    rd = 1;
    #1 check("R1_hold", E_NRD);
    rd = 0;
    // recapture should now take effect
    @(negedge clk); ale = 1;
    @(negedge clk); ale = 0;
    rd = 1;
    #1 check("R1_capture", E_IDLE);
    rd = 0;
  endtask

  task automatic t_pulse_end;
    arm = 1;
    latch_addr(16'h4044);
    rd = 1;
    #1 check("R9_fly_on", E_FLY);
    #2 rd = 0;
    #1 check("R9_fly_off", E_IDLE);
    if (sram_oe && nic_rd) begin
      failures++; $display("FAIL R5 actual=overlap expected=none");
    end
    checks++;
  endtask

  initial begin
    #(CLK_PERIOD * 2000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #1 t_reset();
    @(negedge clk); rst_n = 1;
    t_disarmed();
    t_flyby();
    t_writes();
    t_nic();
    t_unmapped();
    t_hold();
    t_pulse_end();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule